// File: doc/BRIEF.md
# Serial Scratch Memory Slave

This block is a two-wire serial slave that holds a 128-byte scratch array. The controller addresses it with a 7-bit slave address and a read/write bit. The address is made of a fixed `1010` prefix, two strap bits and one device-select bit. The device-select bit tells this slave apart from an information-ROM slave at the neighbouring address, so the two can share a bus.

A write carries a word-address byte that loads the internal pointer, followed by any number of data bytes. Each data byte is stored and the pointer's low three bits advance, so a long write wraps inside its 8-byte page and overwrites earlier bytes there. A read returns the byte at the pointer and advances across the whole array. A repeated start lets a pointer-setting write be followed directly by a read.

The pads are not modelled. SCL and SDA arrive as plain inputs and pass through a synchroniser. The slave pulls the line low through `sda_drive_low_o`, and the board logic combines that with the controller's drive.

The controller sequence (`ST_IDLE`, `ST_ADDR`, `ST_ADDR_ACK`, `ST_WORD`, `ST_WORD_ACK`, `ST_WDATA`, `ST_WDATA_ACK`, `ST_RDATA`, `ST_RACK`) moves as follows:

- **Start and stop (any state):**
  - A start goes to `ST_ADDR`.
  - A stop goes to `ST_IDLE`.
- **`ST_ADDR`:** on the SCL fall that ends the eighth bit:
  - a matching address goes to `ST_ADDR_ACK`;
  - any other address goes back to `ST_IDLE`.
- **`ST_ADDR_ACK`:** at the end of the ninth clock:
  - a read goes to `ST_RDATA`;
  - a write goes to `ST_WORD`.
- **Write path:**
  - `ST_WORD` goes to `ST_WORD_ACK`, which goes to `ST_WDATA`.
  - `ST_WDATA` goes to `ST_WDATA_ACK`, which returns to `ST_WDATA`.
- **Read path:**
  - `ST_RDATA` goes to `ST_RACK` after eight bits.
  - `ST_RACK` returns to `ST_RDATA` when the controller acknowledges, and goes to `ST_IDLE` when it does not.

Top module: `scratch_smb_slave`

## Requirements
- R1: The slave acknowledges an address byte whose upper seven bits equal `1010`, then `strap_i[1:0]`, then the device-select parameter (default 1). Bit 0 of the address byte selects the direction: 1 means read, 0 means write.
- R2: An address byte that does not match gets no acknowledge. The slave then drives nothing, including during later bytes, until the next start condition.
- R3: A start (SDA falls while SCL is high) clears the bit counter and begins a new address byte, even in the middle of a byte. A stop (SDA rises while SCL is high) returns the slave to idle. After reset the slave drives nothing.
- R4: Bits are taken MSB first on SCL rising edges. The acknowledge is held low across the whole ninth clock pulse.
- R5: The byte after a write address loads the pointer from its low seven bits; bit 7 is ignored. Every byte received after a matching write address is acknowledged.
- R6: Each data byte written advances only the low three bits of the pointer, wrapping within its 8-byte page. A ninth byte overwrites the first byte's location, and no location outside the page changes.
- R7: A read sends the byte at the pointer, MSB first, then advances the pointer across the full array, from 0x7F to 0x00.
- R8: When the controller does not acknowledge a read byte, the slave releases SDA and sends nothing more.
- R9: A repeated start after the word-address byte is accepted without a stop, and the following read starts at the address just written.
- R10: The slave changes its SDA drive only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to sample the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock level from the bus |
| sda_i | input | 1 | Serial data level from the bus |
| strap_i | input | 2 | Board strap bits forming address bits 2:1 |
| sda_drive_low_o | output | 1 | Pull SDA low when 1 |

## Verification
The assertions assume several things about the controller:

- SCL and SDA each stay at a level for several system clocks, so that the synchronised copies show every edge.
- The controller changes SDA while SCL is high only to make a start or a stop.
- The controller never makes a start or a stop while the slave is pulling SDA low.

The bench drives each quarter of an SCL period for ten system clocks. It moves its own SDA only in the low phase, except when it deliberately forms start and stop conditions. It combines its drive with the slave's drive as a wired-AND, so the slave always sees the true bus level.

// File: rtl/scratch_smb_pkg.sv
package scratch_smb_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_WORD,
        ST_WORD_ACK,
        ST_WDATA,
        ST_WDATA_ACK,
        ST_RDATA,
        ST_RACK
    } smb_state_t;

    localparam logic [3:0] ADDR_PREFIX = 4'b1010;
    localparam int         BYTE_BITS   = 8;

endpackage

// File: rtl/smb_line_sampler.sv
module smb_line_sampler #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_hi,
    output logic sda_bit,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_ev,
    output logic stop_ev
);

    logic [SYNC_STAGES-1:0] scl_sync;
    logic [SYNC_STAGES-1:0] sda_sync;
    logic                   scl_prev;
    logic                   sda_prev;
    logic                   scl_now;
    logic                   sda_now;

    generate
        if (SYNC_STAGES == 1) begin : g_single
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    scl_sync <= '1;
                    sda_sync <= '1;
                end else begin
                    scl_sync <= scl_i;
                    sda_sync <= sda_i;
                end
            end
        end else begin : g_chain
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    scl_sync <= '1;
                    sda_sync <= '1;
                end else begin
                    scl_sync <= {scl_sync[SYNC_STAGES-2:0], scl_i};
                    sda_sync <= {sda_sync[SYNC_STAGES-2:0], sda_i};
                end
            end
        end
    endgenerate

    assign scl_now = scl_sync[SYNC_STAGES-1];
    assign sda_now = sda_sync[SYNC_STAGES-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_prev <= 1'b1;
            sda_prev <= 1'b1;
        end else begin
            scl_prev <= scl_now;
            sda_prev <= sda_now;
        end
    end

    assign scl_hi   = scl_now;
    assign sda_bit  = sda_now;
    assign scl_rise = scl_now & ~scl_prev;
    assign scl_fall = ~scl_now & scl_prev;
    assign start_ev = scl_now & scl_prev & sda_prev & ~sda_now;
    assign stop_ev  = scl_now & scl_prev & ~sda_prev & sda_now;

endmodule

// File: rtl/scratch_array.sv
module scratch_array #(
    parameter int DEPTH = 128,
    parameter int DW    = 8,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[addr] <= wdata;
        end
    end

    assign rdata = mem[addr];

endmodule

// File: rtl/scratch_smb_slave.sv
module scratch_smb_slave
    import scratch_smb_pkg::*;
#(
    parameter int DEPTH       = 128,
    parameter int PAGE        = 8,
    parameter bit DEV_SEL     = 1'b1,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    input  logic [1:0] strap_i,
    output logic       sda_drive_low_o
);

    localparam int AW = $clog2(DEPTH);
    localparam int PW = $clog2(PAGE);
    localparam int CW = $clog2(BYTE_BITS + 1);

    logic scl_hi, sda_bit, scl_rise, scl_fall, start_ev, stop_ev;

    smb_line_sampler #(.SYNC_STAGES(SYNC_STAGES)) u_sampler (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_i    (scl_i),
        .sda_i    (sda_i),
        .scl_hi   (scl_hi),
        .sda_bit  (sda_bit),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .start_ev (start_ev),
        .stop_ev  (stop_ev)
    );

    smb_state_t           state_q, state_n;
    logic [CW-1:0]        cnt_q, cnt_n;
    logic [BYTE_BITS-1:0] sh_q, sh_n;
    logic [BYTE_BITS-1:0] tx_q, tx_n;
    logic [AW-1:0]        ptr_q, ptr_n;
    logic                 rw_q, rw_n;
    logic                 mack_q, mack_n;
    logic                 mem_we;
    logic [BYTE_BITS-1:0] mem_rdata;
    logic                 byte_done;
    logic [6:0]           own_addr;

    scratch_array #(.DEPTH(DEPTH), .DW(BYTE_BITS)) u_array (
        .clk   (clk),
        .we    (mem_we),
        .addr  (ptr_q),
        .wdata (sh_q),
        .rdata (mem_rdata)
    );

    assign own_addr  = {ADDR_PREFIX, strap_i, DEV_SEL};
    assign byte_done = scl_fall && (cnt_q == CW'(BYTE_BITS));

    // next-state and datapath
    always_comb begin
        state_n = state_q;
        cnt_n   = cnt_q;
        sh_n    = sh_q;
        tx_n    = tx_q;
        ptr_n   = ptr_q;
        rw_n    = rw_q;
        mack_n  = mack_q;
        mem_we  = 1'b0;
        if (stop_ev) begin
            state_n = ST_IDLE;
            cnt_n   = '0;
        end else if (start_ev) begin
            state_n = ST_ADDR;
            cnt_n   = '0;
        end else begin
            unique case (state_q)
                ST_IDLE: ;
                ST_ADDR, ST_WORD, ST_WDATA: begin
                    if (scl_rise) begin
                        sh_n  = {sh_q[BYTE_BITS-2:0], sda_bit};
                        cnt_n = cnt_q + CW'(1);
                    end else if (byte_done) begin
                        cnt_n = '0;
                        if (state_q == ST_ADDR) begin
                            rw_n    = sh_q[0];
                            state_n = (sh_q[7:1] == own_addr) ? ST_ADDR_ACK : ST_IDLE;
                        end else if (state_q == ST_WORD) begin
                            ptr_n   = sh_q[AW-1:0];
                            state_n = ST_WORD_ACK;
                        end else begin
                            mem_we  = 1'b1;
                            ptr_n   = {ptr_q[AW-1:PW], ptr_q[PW-1:0] + PW'(1)};
                            state_n = ST_WDATA_ACK;
                        end
                    end
                end
                ST_ADDR_ACK: begin
                    if (scl_fall) begin
                        if (rw_q) begin
                            state_n = ST_RDATA;
                            tx_n    = mem_rdata;
                            cnt_n   = '0;
                        end else begin
                            state_n = ST_WORD;
                        end
                    end
                end
                ST_WORD_ACK, ST_WDATA_ACK: begin
                    if (scl_fall) state_n = ST_WDATA;
                end
                ST_RDATA: begin
                    if (scl_rise) begin
                        cnt_n = cnt_q + CW'(1);
                    end else if (byte_done) begin
                        cnt_n   = '0;
                        ptr_n   = ptr_q + AW'(1);
                        state_n = ST_RACK;
                    end else if (scl_fall) begin
                        tx_n = {tx_q[BYTE_BITS-2:0], 1'b0};
                    end
                end
                ST_RACK: begin
                    if (scl_rise) begin
                        mack_n = ~sda_bit;
                    end else if (scl_fall) begin
                        if (mack_q) begin
                            state_n = ST_RDATA;
                            tx_n    = mem_rdata;
                        end else begin
                            state_n = ST_IDLE;
                        end
                    end
                end
                default: state_n = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            sh_q    <= '0;
            tx_q    <= '0;
            ptr_q   <= '0;
            rw_q    <= 1'b0;
            mack_q  <= 1'b0;
        end else begin
            state_q <= state_n;
            cnt_q   <= cnt_n;
            sh_q    <= sh_n;
            tx_q    <= tx_n;
            ptr_q   <= ptr_n;
            rw_q    <= rw_n;
            mack_q  <= mack_n;
        end
    end

    // outputs
    always_comb begin
        unique case (state_q)
            ST_ADDR_ACK, ST_WORD_ACK, ST_WDATA_ACK: sda_drive_low_o = 1'b1;
            ST_RDATA:                               sda_drive_low_o = ~tx_q[BYTE_BITS-1];
            default:                                sda_drive_low_o = 1'b0;
        endcase
    end

    assert_idle_until_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && !start_ev) |=> state_q == ST_IDLE);

    assert_start_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
        start_ev && !stop_ev |=> (cnt_q == '0 && state_q == ST_ADDR));

    assert_stop_idles_R3: assert property (@(posedge clk) disable iff (!rst_n)
        stop_ev |=> state_q == ST_IDLE);

    assert_cnt_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CW'(BYTE_BITS));

    assert_page_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> (ptr_q[AW-1:PW] == $past(ptr_q[AW-1:PW]) &&
                    ptr_q[PW-1:0] == PW'($past(ptr_q[PW-1:0]) + 1'b1)));

    assert_read_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RACK && $past(state_q) == ST_RDATA) |-> ptr_q == AW'($past(ptr_q) + 1'b1));

    assert_scl_high_stable_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_hi && $past(scl_hi) && !$past(start_ev) && !$past(stop_ev)) |-> $stable(sda_drive_low_o));

endmodule

// File: tb/scratch_smb_slave_bench.sv
module scratch_smb_slave_bench;

    localparam int Q        = 10;
    localparam int WATCHDOG = 190000;
    localparam logic [7:0] AW_W = 8'hAA;
    localparam logic [7:0] AW_R = 8'hAB;

    // each entry: {word address, data}; written then read back
    localparam logic [15:0] VEC [6] = '{16'h005A, 16'h07FF, 16'h2C00,
                                        16'h4181, 16'h7E3C, 16'h85A7};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic drv;
    logic sda_bus;
    int   n_chk = 0;
    int   n_fail = 0;
    int   cyc = 0;
    int   r10_viol = 0;
    logic prev_scl = 1'b1;
    logic prev_drv = 1'b0;

    always #10 clk = ~clk;

    assign sda_bus = sda_m & ~drv;

    scratch_smb_slave u_scratch_smb_slave (
        .clk             (clk),
        .rst_n           (rst_n),
        .scl_i           (scl_m),
        .sda_i           (sda_bus),
        .strap_i         (2'b10),
        .sda_drive_low_o (drv)
    );

    task automatic summary_and_end();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == WATCHDOG) begin
            n_chk  = n_chk + 1;
            n_fail = n_fail + 1;
            $display("FAIL watchdog: run hung, actual %0d cycles expected fewer", cyc);
            summary_and_end();
        end
    end

    // R10 monitor: slave drive must not move while SCL stays high
    always @(negedge clk) begin
        if (rst_n && scl_m && prev_scl && (drv !== prev_drv)) r10_viol = r10_viol + 1;
        prev_scl = scl_m;
        prev_drv = drv;
    end

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk = n_chk + 1;
        if (act !== exp) begin
            n_fail = n_fail + 1;
            $display("FAIL %s actual %02h expected %02h", tag, act, exp);
        end
    endtask

    task automatic waitq();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; waitq();
        scl_m = 1'b1; waitq();
        sda_m = 1'b0; waitq();
        scl_m = 1'b0; waitq();
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; waitq();
        scl_m = 1'b1; waitq();
        sda_m = 1'b1; waitq();
    endtask

    task automatic send_bits(input logic [7:0] b, input int nbits);
        for (int i = 7; i > 7 - nbits; i--) begin
            sda_m = b[i]; waitq();
            scl_m = 1'b1; waitq(); waitq();
            scl_m = 1'b0; waitq();
        end
    endtask

    // returns 1 when the slave held SDA low across the ninth clock
    task automatic send_byte(input logic [7:0] b, output logic ack);
        logic a0;
        logic a1;
        send_bits(b, 8);
        sda_m = 1'b1; waitq();
        scl_m = 1'b1;
        repeat (2) @(negedge clk);
        a0 = ~sda_bus;
        repeat (Q - 2) @(negedge clk);
        a1 = ~sda_bus;
        waitq();
        scl_m = 1'b0; waitq();
        ack = a0 & a1;
    endtask

    task automatic read_byte(input logic nack, output logic [7:0] d);
        sda_m = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            waitq();
            scl_m = 1'b1; waitq();
            d[i] = sda_bus; waitq();
            scl_m = 1'b0; waitq();
        end
        sda_m = nack; waitq();
        scl_m = 1'b1; waitq(); waitq();
        scl_m = 1'b0; waitq();
        sda_m = 1'b1;
    endtask

    task automatic wr_bytes(input logic [7:0] wa, input int n, input logic [8*12-1:0] d);
        logic ack;
        bus_start();
        send_byte(AW_W, ack); chk("R1 write address ack", {7'd0, ack}, 8'h01);
        send_byte(wa, ack);   chk("R5 word address ack", {7'd0, ack}, 8'h01);
        for (int k = 0; k < n; k++) begin
            send_byte(d[8*k +: 8], ack);
            chk("R5 data byte ack", {7'd0, ack}, 8'h01);
        end
        bus_stop();
    endtask

    task automatic rd_bytes(input logic [7:0] wa, input int n, output logic [8*12-1:0] q,
                            output logic drv_after);
        logic       ack;
        logic [7:0] b;
        q = '0;
        bus_start();
        send_byte(AW_W, ack); chk("R9 pointer write address ack", {7'd0, ack}, 8'h01);
        send_byte(wa, ack);   chk("R9 pointer word ack", {7'd0, ack}, 8'h01);
        bus_start();
        send_byte(AW_R, ack); chk("R9 repeated start read address ack", {7'd0, ack}, 8'h01);
        for (int k = 0; k < n; k++) begin
            read_byte(k == n - 1, b);
            q[8*k +: 8] = b;
        end
        repeat (4) @(negedge clk);
        drv_after = drv;
        bus_stop();
    endtask

    initial begin
        logic [8*12-1:0] q;
        logic            da;
        logic            ack;

        repeat (5) @(negedge clk);
        chk("R3 drive during reset", {7'd0, drv}, 8'h00);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        chk("R3 drive after reset", {7'd0, drv}, 8'h00);

        // vector table: single write then random read (bit 7 of word address ignored, R5)
        for (int v = 0; v < 6; v++) begin
            wr_bytes(VEC[v][15:8], 1, {88'd0, VEC[v][7:0]});
            rd_bytes({1'b0, VEC[v][14:8]}, 1, q, da);
            chk("R7 R4 readback of vector", q[7:0], VEC[v][7:0]);
        end

        // R2: neighbouring device-select address and wrong strap are not acknowledged
        bus_start();
        send_byte(8'hA8, ack); chk("R2 neighbour address no ack", {7'd0, ack}, 8'h00);
        send_byte(8'h00, ack); chk("R2 idle after mismatch", {7'd0, ack}, 8'h00);
        bus_stop();
        bus_start();
        send_byte(8'hA6, ack); chk("R2 strap mismatch no ack", {7'd0, ack}, 8'h00);
        bus_start();
        send_byte(AW_W, ack); chk("R2 new start recovers", {7'd0, ack}, 8'h01);
        bus_stop();

        // R3: start in the middle of a byte clears the bit counter
        bus_start();
        send_bits(8'hFF, 3);
        bus_start();
        send_byte(AW_W, ack); chk("R3 address after mid-byte start", {7'd0, ack}, 8'h01);
        send_byte(8'h30, ack); chk("R3 word after mid-byte start", {7'd0, ack}, 8'h01);
        send_byte(8'h77, ack); chk("R3 data after mid-byte start", {7'd0, ack}, 8'h01);
        bus_stop();
        rd_bytes(8'h30, 1, q, da);
        chk("R3 data stored after restart", q[7:0], 8'h77);

        // R6: nine bytes from 0x13 wrap in page 0x10..0x17; 0x18 untouched
        wr_bytes(8'h18, 1, {88'd0, 8'hA5});
        wr_bytes(8'h13, 9, {24'd0, 8'hD8, 8'hD7, 8'hD6, 8'hD5, 8'hD4,
                                   8'hD3, 8'hD2, 8'hD1, 8'hD0});
        rd_bytes(8'h10, 9, q, da);
        for (int a = 0; a < 8; a++) begin
            logic [7:0] e;
            int         k;
            k = (a + 5) % 8;
            e = (a == 3) ? 8'hD8 : (8'hD0 + 8'(k));
            chk("R6 page wrap contents", q[8*a +: 8], e);
        end
        chk("R6 R7 byte past page unchanged", q[71:64], 8'hA5);

        // R7 / R8: read rolls over the array top, NACK releases the line
        wr_bytes(8'h7F, 1, {88'd0, 8'h96});
        wr_bytes(8'h00, 1, {88'd0, 8'h6B});
        wr_bytes(8'h01, 1, {88'd0, 8'h12});
        rd_bytes(8'h7F, 2, q, da);
        chk("R7 byte at 0x7F", q[7:0], 8'h96);
        chk("R7 rollover to 0x00", q[15:8], 8'h6B);
        chk("R8 released after NACK", {7'd0, da}, 8'h00);

        chk("R10 drive moved while SCL high", 8'(r10_viol), 8'h00);
        summary_and_end();
    end

endmodule